// File: doc/BRIEF.md
# Bank-Switched Debug Signal Router

This block brings internal probe signals out to a fixed group of 16 debug pins, where an external logic analyzer can capture them. The probe signals come in equal banks, each 16 bits wide. A slow serial port, separate from the probe clock, picks which bank drives the pins. The design does not have to be rebuilt to change the bank.

A build-time parameter picks one of two output paths. In timing mode the chosen bank reaches the pins through logic alone, with no storage on the way. This suits asynchronous capture of glitches and of signals from several clock domains. In state mode the chosen bank passes through four registers clocked by the probe clock. The block also drives a forwarded clock, the inverse of the probe clock. Data changes on that clock's falling edge, so the analyzer can sample it on the rising edge. One state-mode instance serves one clock domain.

On each rising edge of the serial clock, the serial port shifts in a 6-bit bank index, least significant bit first. A separate update strobe copies the shifted index into a holding register and flips a toggle flag. The toggle crosses into the probe domain through a two-flop synchronizer. Only after the synchronized toggle changes is the new index loaded into the active select. A bank change therefore always lands between two probe clock edges.

Top module: `dbg_bank_router`

## Requirements
- R1: While reset is held, the state-mode pin outputs are zero and the active select is bank 0. In timing mode this means the pins show bank 0. After reset is released, bank 0 stays selected until the first update.
- R2: On each rising edge of `cfg_clk` with `cfg_update` low, `cfg_din` is shifted in, least significant bit first, as a 6-bit index. A rising edge with `cfg_update` high does not shift. Instead it copies the six bits shifted in so far into the pending index and flips the transfer toggle.
- R3: Shifting bits without an update strobe leaves the active bank unchanged.
- R4: A new index takes effect in the probe domain only after two synchronizer flops. The pins still show the old bank at the first probe edge after the strobe. They show the new bank no more than six probe cycles later. The active select changes only on the probe cycle after the synchronized toggle changes.
- R5: An index equal to or greater than `NUM_BANKS` selects bank 0.
- R6: In state mode, `pin_data` equals the selected bank's value four probe rising edges earlier.
- R7: In state mode, `pin_clk` is the inverse of `probe_clk`. It is high while `probe_clk` is low and low while `probe_clk` is high.
- R8: In timing mode, `pin_data` follows the selected bank within the same cycle, with no register on the path, and `pin_clk` is held at 0.
- R9: `NUM_BANKS` must lie between 1 and 64, or elaboration fails. Bank i occupies bits [16*i+15 : 16*i] of `probe_banks`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| probe_clk | input | 1 | Clock of the probed domain |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| probe_banks | input | NUM_BANKS*16 | Probe banks, concatenated, bank 0 in the low bits |
| cfg_clk | input | 1 | Serial configuration clock (below 5 MHz) |
| cfg_din | input | 1 | Serial index data, least significant bit first |
| cfg_update | input | 1 | Strobe that moves the shifted index to the pending register |
| pin_data | output | 16 | Debug pin data |
| pin_clk | output | 1 | Forwarded sampling clock (state mode), 0 in timing mode |

## Verification
Three kinds of internal fault show at the pins in different ways.
- **Wrong select or clamp:** the pins carry the wrong bank's pattern. This is visible on the first cycle in timing mode, and four cycles later in state mode, because every probe cycle carries fresh random bank contents.
- **Pipeline depth or reset fault:** the output stream is shifted against the expected queue by one or more cycles, or shows non-zero data while reset is held.
- **Synchronizer or strobe fault:** the bank switches too early (on the first probe edge after the strobe), switches too late, or switches while only bits are being shifted.

// File: rtl/dbgr_pkg.sv
package dbgr_pkg;
   localparam int PIN_W       = 16;
   localparam int SEL_W       = 6;
   localparam int MAX_BANKS   = 1 << SEL_W;
   localparam int STATE_DEPTH = 4;
   localparam int SYNC_LEN    = 2;

   typedef enum logic {
      MODE_TIMING = 1'b0,
      MODE_STATE  = 1'b1
   } route_mode_e;

   typedef logic [PIN_W-1:0] pin_word_t;
   typedef logic [SEL_W-1:0] bank_idx_t;

   function automatic bank_idx_t clamp_idx(bank_idx_t idx, int n_banks);
      return (int'(idx) >= n_banks) ? '0 : idx;
   endfunction
endpackage

// File: rtl/dbgr_cfg_shift.sv
module dbgr_cfg_shift
   import dbgr_pkg::*;
(
   input  logic      cfg_clk,
   input  logic      rst_n,
   input  logic      cfg_din,
   input  logic      cfg_update,
   output bank_idx_t pend_idx,
   output logic      pend_tog
);
   bank_idx_t shreg;

   always_ff @(posedge cfg_clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg    <= '0;
         pend_idx <= '0;
         pend_tog <= 1'b0;
      end else if (cfg_update) begin
         pend_idx <= shreg;
         pend_tog <= ~pend_tog;
      end else begin
         shreg <= {cfg_din, shreg[SEL_W-1:1]};
      end
   end
endmodule

// File: rtl/dbgr_sel_sync.sv
module dbgr_sel_sync
   import dbgr_pkg::*;
#(
   parameter int NUM_BANKS = 8
) (
   input  logic      probe_clk,
   input  logic      rst_n,
   input  bank_idx_t pend_idx,
   input  logic      pend_tog,
   output bank_idx_t sel_q,
   output logic      sel_chg
);
   localparam int CHAIN = SYNC_LEN + 1;

   logic [CHAIN-1:0] sync_q;

   always_ff @(posedge probe_clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[CHAIN-2:0], pend_tog};
   end

   assign sel_chg = sync_q[SYNC_LEN-1] ^ sync_q[SYNC_LEN];

   always_ff @(posedge probe_clk or negedge rst_n) begin
      if (!rst_n)       sel_q <= '0;
      else if (sel_chg) sel_q <= clamp_idx(pend_idx, NUM_BANKS);
   end
endmodule

// File: rtl/dbgr_bank_mux.sv
module dbgr_bank_mux
   import dbgr_pkg::*;
#(
   parameter int NUM_BANKS = 8
) (
   input  logic [NUM_BANKS*PIN_W-1:0] banks,
   input  bank_idx_t                  sel,
   output pin_word_t                  word
);
   pin_word_t slice [NUM_BANKS];

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_slice
      assign slice[g] = banks[g*PIN_W +: PIN_W];
   end

   always_comb begin
      word = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (sel == SEL_W'(b)) word = slice[b];
      end
   end
endmodule

// File: rtl/dbgr_out_stage.sv
module dbgr_out_stage
   import dbgr_pkg::*;
#(
   parameter route_mode_e MODE  = MODE_STATE,
   parameter int          DEPTH = STATE_DEPTH
) (
   input  logic      clk,
   input  logic      rst_n,
   input  pin_word_t d,
   output pin_word_t q,
   output logic      clk_fwd
);
   if (MODE == MODE_STATE) begin : g_state
      pin_word_t stg [DEPTH];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) stg[k] <= '0;
         end else begin
            stg[0] <= d;
            for (int k = 1; k < DEPTH; k++) stg[k] <= stg[k-1];
         end
      end

      assign q       = stg[DEPTH-1];
      assign clk_fwd = ~clk;
   end else begin : g_timing
      logic unused_ctl;
      assign unused_ctl = clk ^ rst_n;
      assign q          = d;
      assign clk_fwd    = 1'b0;
   end
endmodule

// File: rtl/dbg_bank_router.sv
module dbg_bank_router
   import dbgr_pkg::*;
#(
   parameter int          NUM_BANKS = 8,
   parameter route_mode_e MODE      = MODE_STATE
) (
   input  logic                       probe_clk,
   input  logic                       rst_n,
   input  logic [NUM_BANKS*PIN_W-1:0] probe_banks,
   input  logic                       cfg_clk,
   input  logic                       cfg_din,
   input  logic                       cfg_update,
   output logic [PIN_W-1:0]           pin_data,
   output logic                       pin_clk
);
   // R9: the bank count must fit the 6-bit index
   if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS) begin : g_bad_banks
      $error("dbg_bank_router: NUM_BANKS out of range 1..64");
   end
   if (STATE_DEPTH < 1) begin : g_bad_depth
      $error("dbg_bank_router: STATE_DEPTH must be positive");
   end

   bank_idx_t pend_idx;
   logic      held_tog;
   bank_idx_t sel_q;
   logic      sel_chg;
   pin_word_t mux_word;

   dbgr_cfg_shift u_cfg (
      .cfg_clk   (cfg_clk),
      .rst_n     (rst_n),
      .cfg_din   (cfg_din),
      .cfg_update(cfg_update),
      .pend_idx  (pend_idx),
      .pend_tog  (held_tog)
   );

   dbgr_sel_sync #(.NUM_BANKS(NUM_BANKS)) u_sync (
      .probe_clk(probe_clk),
      .rst_n    (rst_n),
      .pend_idx (pend_idx),
      .pend_tog (held_tog),
      .sel_q    (sel_q),
      .sel_chg  (sel_chg)
   );

   dbgr_bank_mux #(.NUM_BANKS(NUM_BANKS)) u_mux (
      .banks(probe_banks),
      .sel  (sel_q),
      .word (mux_word)
   );

   dbgr_out_stage #(.MODE(MODE), .DEPTH(STATE_DEPTH)) u_out (
      .clk    (probe_clk),
      .rst_n  (rst_n),
      .d      (mux_word),
      .q      (pin_data),
      .clk_fwd(pin_clk)
   );
endmodule

// File: rtl/dbgr_checker.sv
module dbgr_checker
   import dbgr_pkg::*;
#(
   parameter int          NUM_BANKS = 8,
   parameter route_mode_e MODE      = MODE_STATE
) (
   input logic      probe_clk,
   input logic      rst_n,
   input logic      cfg_clk,
   input logic      cfg_update,
   input logic      held_tog,
   input bank_idx_t sel_q,
   input logic      sel_chg,
   input pin_word_t mux_word,
   input pin_word_t pin_data,
   input logic      pin_clk
);
   logic unused_pins;
   assign unused_pins = ^{pin_clk, mux_word, pin_data};

   // R2: a strobe edge flips the transfer toggle
   a_r2_update_toggles: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      cfg_update |=> (held_tog != $past(held_tog)));

   // R2: shift edges leave the toggle alone
   a_r2_shift_keeps_toggle: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      !cfg_update |=> (held_tog == $past(held_tog)));

   // R4: select moves only after a synchronized toggle change
   a_r4_sel_waits_sync: assert property (@(posedge probe_clk) disable iff (!rst_n)
      !sel_chg |=> $stable(sel_q));

   // R5: the active select always names an existing bank
   a_r5_sel_in_range: assert property (@(posedge probe_clk) disable iff (!rst_n)
      int'(sel_q) < NUM_BANKS);

   if (MODE == MODE_STATE) begin : g_state_chk
      logic [2:0] since_rst;
      always_ff @(posedge probe_clk or negedge rst_n) begin
         if (!rst_n)               since_rst <= '0;
         else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
      end

      // R6: four register stages from the mux to the pins
      a_r6_four_stage_delay: assert property (@(posedge probe_clk) disable iff (!rst_n)
         (since_rst >= 3'd4) |-> (pin_data == $past(mux_word, 4)));
   end else begin : g_timing_chk
      // R8: no register on the path, forwarded clock parked low
      a_r8_comb_path: assert property (@(posedge probe_clk) disable iff (!rst_n)
         (pin_data == mux_word) && (pin_clk == 1'b0));
   end
endmodule

bind dbg_bank_router dbgr_checker #(.NUM_BANKS(NUM_BANKS), .MODE(MODE)) u_dbgr_chk (
   .probe_clk (probe_clk),
   .rst_n     (rst_n),
   .cfg_clk   (cfg_clk),
   .cfg_update(cfg_update),
   .held_tog  (held_tog),
   .sel_q     (sel_q),
   .sel_chg   (sel_chg),
   .mux_word  (mux_word),
   .pin_data  (pin_data),
   .pin_clk   (pin_clk)
);

// File: tb/dbg_bank_router_bench.sv
module dbg_bank_router_bench;
   localparam int NB  = 8;
   localparam int W   = 16;
   localparam int LAT = 4;

   logic          probe_clk = 1'b0;
   logic          rst_n     = 1'b0;
   logic [NB*W-1:0] probe_banks = '0;
   logic          cfg_clk = 1'b0;
   logic          cfg_din = 1'b0;
   logic          cfg_update = 1'b0;
   logic [W-1:0]  pin_s, pin_t;
   logic          pclk_s, pclk_t;

   int n_cmp = 0;
   int n_bad = 0;
   logic [W-1:0] expq [$];

   always #5 probe_clk = ~probe_clk;

   dbg_bank_router #(.NUM_BANKS(NB), .MODE(dbgr_pkg::MODE_STATE)) u_dbg_bank_router (
      .probe_clk(probe_clk), .rst_n(rst_n), .probe_banks(probe_banks),
      .cfg_clk(cfg_clk), .cfg_din(cfg_din), .cfg_update(cfg_update),
      .pin_data(pin_s), .pin_clk(pclk_s));

   dbg_bank_router #(.NUM_BANKS(NB), .MODE(dbgr_pkg::MODE_TIMING)) u_dbg_bank_router_tm (
      .probe_clk(probe_clk), .rst_n(rst_n), .probe_banks(probe_banks),
      .cfg_clk(cfg_clk), .cfg_din(cfg_din), .cfg_update(cfg_update),
      .pin_data(pin_t), .pin_clk(pclk_t));

   function automatic logic [W-1:0] bank_val(int b);
      return probe_banks[b*W +: W];
   endfunction

   task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic randomize_banks();
      for (int b = 0; b < NB; b++) probe_banks[b*W +: W] = W'($urandom);
   endtask

   // monitor: pops the scoreboard when the pipeline has delivered an item
   task automatic monitor_step();
      if (expq.size() == LAT) chk("R6 state pipeline data", pin_s, expq.pop_front());
      chk("R7 forwarded clock high while probe clock low", {15'b0, pclk_s}, 16'd1);
   endtask

   // driver: one probe cycle of fresh data, expected item pushed
   task automatic drive_cycle(int sel);
      @(negedge probe_clk);
      monitor_step();
      randomize_banks();
      expq.push_back(bank_val(sel));
      #1;
      chk("R8/R9 timing path same cycle", pin_t, bank_val(sel));
      chk("R8 timing forwarded clock low", {15'b0, pclk_t}, 16'd0);
   endtask

   task automatic stream(int n, int sel);
      expq.delete();
      repeat (n) drive_cycle(sel);
   endtask

   task automatic cfg_edge();
      #200 cfg_clk = 1'b1;
      #200 cfg_clk = 1'b0;
   endtask

   // R2: six bits, least significant first
   task automatic shift_idx(int v);
      for (int i = 0; i < 6; i++) begin
         cfg_din = v[i];
         cfg_edge();
      end
   endtask

   task automatic pulse_update(int old_sel, int new_sel);
      cfg_update = 1'b1;
      #200 cfg_clk = 1'b1;
      @(negedge probe_clk);
      #1 chk("R4 no switch before synchronizer", pin_t, bank_val(old_sel));
      repeat (6) @(negedge probe_clk);
      #1 chk("R4 switched after synchronizer", pin_t, bank_val(new_sel));
      #180 cfg_clk = 1'b0;
      cfg_update = 1'b0;
   endtask

   task automatic load_sel(int v, int old_sel, int new_sel);
      @(negedge probe_clk);
      #3;
      shift_idx(v);
      pulse_update(old_sel, new_sel);
   endtask

   initial begin
      randomize_banks();
      repeat (3) @(negedge probe_clk);
      #1;
      chk("R1 state pins zero in reset", pin_s, '0);
      chk("R1 timing pins show bank 0 in reset", pin_t, bank_val(0));
      @(negedge probe_clk);
      rst_n = 1'b1;
      stream(12, 0);                        // R1 default bank
      @(posedge probe_clk);
      #1 chk("R7 forwarded clock low while probe clock high", {15'b0, pclk_s}, 16'd0);

      load_sel(3, 0, 3);
      stream(12, 3);
      load_sel(NB-1, 3, NB-1);              // R9 top bank
      stream(12, NB-1);

      // R3: shift without a strobe
      @(negedge probe_clk);
      #3 shift_idx(5);
      repeat (8) @(negedge probe_clk);
      #1 chk("R3 shift alone keeps bank", pin_t, bank_val(NB-1));
      stream(12, NB-1);
      // R2: strobe alone applies the bits shifted earlier
      @(negedge probe_clk);
      #3 pulse_update(NB-1, 5);
      stream(12, 5);

      load_sel(NB, 5, 0);                   // R5 first out-of-range value
      stream(12, 0);
      load_sel(2, 0, 2);
      load_sel(63, 2, 0);                   // R5 largest index
      stream(12, 0);
      load_sel(1, 0, 1);
      stream(12, 1);

      // R1: reset in mid-stream
      @(negedge probe_clk);
      rst_n = 1'b0;
      #1;
      chk("R1 state pins cleared by reset", pin_s, '0);
      chk("R1 select back to bank 0", pin_t, bank_val(0));
      @(negedge probe_clk);
      rst_n = 1'b1;
      stream(12, 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #2_000_000;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule